// File: doc/BRIEF.md
# Pin Output Latch with Atomic Bit Aliases

This block is a 32-pin general-purpose I/O data port on a simple word-wide register bus. It holds an output latch, which drives the pad output values, and a direction register, which drives the pad output enables. Software can load the latch as a whole. It can also change only chosen bits through three write-only alias addresses: one forces the chosen bits high, one forces them low, and one inverts them. Because each alias touches only the bits written as one, no read-modify-write sequence is needed. Two agents sharing the port therefore cannot undo each other's updates.

Pad input levels pass through a two-stage synchronizer before software can see them, at a read-only address. A bus access is a single-cycle request with a write flag. Read data is registered and appears on the cycle after the request. The read data output then holds its value until the next read.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted and after it is released, the output latch, the direction register, the pad outputs, the pad output enables and the read data are all zero.
- R2: A write to byte address 0x00 loads the whole output latch. A read of 0x00 returns the latch.
- R3: A write to 0x04 forces high each latch bit whose written bit is 1. All other latch bits keep their value.
- R4: A write to 0x08 forces low each latch bit whose written bit is 1. All other latch bits keep their value.
- R5: A write to 0x0C inverts each latch bit whose written bit is 1. All other latch bits keep their value.
- R6: A write to 0x14 loads the direction register, where 1 means output and 0 means input. A read of 0x14 returns it. Each pad output enable equals its direction bit from the clock edge that performed the write.
- R7: A read of 0x10 returns the pad input levels as they were sampled two rising edges before the edge that takes the read. Writes to 0x10 change nothing.
- R8: Reads of 0x04, 0x08 and 0x0C return zero.
- R9: Read data is loaded at the clock edge that samples a read request. It holds its value through idle cycles and writes.
- R10: The pad outputs equal the output latch for every pin, whatever the direction bit.
- R11: An address whose two low bits are not zero, or an address above 0x14, selects nothing. A write to it changes no register, and a read of it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | 32 | Pad input levels, asynchronous |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |

## Verification
The latch and alias properties compare the pad outputs with the write data from one cycle earlier. They assume that `we_i` and `addr_i` are stable, known values whenever `req_i` is high; the bench drives all bus inputs only on falling edges. The pin-read property looks three cycles into the past, which reaches back into the reset interval. It is valid only because the pad inputs are held at zero during reset and for several cycles after it; the bench changes the pad inputs only once that window has passed.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int unsigned BYTE_OFS_W = 2;

  typedef enum logic [2:0] {
    SEL_DOUT = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_TOG  = 3'd3,
    SEL_PIN  = 3'd4,
    SEL_DIR  = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam int unsigned IDX_W = ADDR_W - BYTE_OFS_W;

  logic [IDX_W-1:0] word_idx;
  assign word_idx = addr_i[ADDR_W-1:BYTE_OFS_W];

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[BYTE_OFS_W-1:0] == '0) begin
      case (word_idx)
        IDX_W'(0): sel_o = SEL_DOUT;
        IDX_W'(1): sel_o = SEL_SET;
        IDX_W'(2): sel_o = SEL_CLR;
        IDX_W'(3): sel_o = SEL_TOG;
        IDX_W'(4): sel_o = SEL_PIN;
        IDX_W'(5): sel_o = SEL_DIR;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] out_q_o,
  output logic [W-1:0] dir_q_o
);
  logic [W-1:0] out_q, out_d, dir_q, dir_d;

  // alias writes only touch bits written as one
  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    if (wr_en_i) begin
      case (sel_i)
        SEL_DOUT: out_d = wdata_i;
        SEL_SET:  out_d = out_q | wdata_i;
        SEL_CLR:  out_d = out_q & ~wdata_i;
        SEL_TOG:  out_d = out_q ^ wdata_i;
        SEL_DIR:  dir_d = wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  assign out_q_o = out_q;
  assign dir_q_o = dir_q;
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= async_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_rd_mux.sv
`timescale 1ns/1ps
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_en_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] out_q_i,
  input  logic [W-1:0] dir_q_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] rd_d, rd_q;

  // aliases and unmapped addresses read as zero
  always_comb begin
    case (sel_i)
      SEL_DOUT: rd_d = out_q_i;
      SEL_PIN:  rd_d = pin_i;
      SEL_DIR:  rd_d = dir_q_i;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pad_in_i,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o
);
  reg_sel_e     sel;
  logic [W-1:0] out_q, dir_q, pin_sync;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  gpio_out_latch #(.W(W)) i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (req_i & we_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .out_q_o (out_q),
    .dir_q_o (dir_q)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (pin_sync)
  );

  gpio_rd_mux #(.W(W)) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (req_i & ~we_i),
    .sel_i   (sel),
    .out_q_i (out_q),
    .dir_q_i (dir_q),
    .pin_i   (pin_sync),
    .rdata_o (rdata_o)
  );

  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
`timescale 1ns/1ps
module gpio_port_regs_chk #(
  parameter int unsigned W           = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      rdata_o,
  input logic [W-1:0]      pad_in_i,
  input logic [W-1:0]      pad_out_o,
  input logic [W-1:0]      pad_oe_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h00) |=> pad_out_o == $past(wdata_i));

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h04) |=> pad_out_o == ($past(pad_out_o) | $past(wdata_i)));

  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h08) |=> pad_out_o == ($past(pad_out_o) & ~$past(wdata_i)));

  assert_tog_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h0C) |=> pad_out_o == ($past(pad_out_o) ^ $past(wdata_i)));

  assert_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h14) |=> pad_oe_o == $past(wdata_i));

  assert_alias_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (addr_i == ADDR_W'(8'h04) || addr_i == ADDR_W'(8'h08) || addr_i == ADDR_W'(8'h0C))
    |=> rdata_o == '0);

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr || addr_i[1:0] != 2'b00 |=> $stable(pad_out_o) && $stable(pad_oe_o));

  if (SYNC_STAGES == 2) begin : g_pin_chk
    assert_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd && addr_i == ADDR_W'(8'h10) |=> rdata_o == $past(pad_in_i, 3));
  end
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.W(W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_chk (.*);

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pad_in_i = '0;
  logic [31:0] pad_out_o;
  logic [31:0] pad_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_port_regs i_gpio_port_regs (.*);

  // behavioural reference model
  logic [31:0] m_out, m_dir, m_rd;
  logic [31:0] m_syncq[$];

  function automatic logic [31:0] m_read(logic [7:0] a, logic [31:0] pin);
    case (a)
      8'h00:   return m_out;
      8'h10:   return pin;
      8'h14:   return m_dir;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_out = '0; m_dir = '0; m_rd = '0;
      m_syncq = {32'h0, 32'h0};
    end else begin
      logic [31:0] pin;
      pin = m_syncq[0];
      if (req_i && we_i) begin
        case (addr_i)
          8'h00: m_out = wdata_i;
          8'h04: m_out = m_out | wdata_i;
          8'h08: m_out = m_out & ~wdata_i;
          8'h0C: m_out = m_out ^ wdata_i;
          8'h14: m_dir = wdata_i;
          default: ;
        endcase
      end else if (req_i) begin
        m_rd = m_read(addr_i, pin);
      end
      m_syncq.push_back(pad_in_i);
      void'(m_syncq.pop_front());
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R10 pad_out_o vs model", pad_out_o, m_out);
      chk("R6 pad_oe_o vs model", pad_oe_o, m_dir);
      chk("R9 rdata_o vs model", rdata_o, m_rd);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(tag, rdata_o, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 pad_out_o in reset", pad_out_o, 32'h0);
    chk("R1 pad_oe_o in reset", pad_oe_o, 32'h0);
    chk("R1 rdata_o in reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    rd(8'h00, 32'h0, "R1 latch after reset");
    rd(8'h14, 32'h0, "R1 direction after reset");

    wr(8'h00, 32'hA5A5_0F0F);
    rd(8'h00, 32'hA5A5_0F0F, "R2 latch load");
    chk("R10 pad_out_o with all inputs", pad_out_o, 32'hA5A5_0F0F);

    wr(8'h04, 32'h0000_F0F0);
    rd(8'h00, 32'hA5A5_FFFF, "R3 set alias");
    wr(8'h08, 32'hFFFF_0000);
    rd(8'h00, 32'h0000_FFFF, "R4 clear alias");
    wr(8'h0C, 32'h0F0F_0F0F);
    rd(8'h00, 32'h0F0F_F0F0, "R5 toggle alias");
    wr(8'h0C, 32'h0F0F_0F0F);
    rd(8'h00, 32'h0000_FFFF, "R5 toggle back");

    rd(8'h04, 32'h0, "R8 set alias read");
    rd(8'h08, 32'h0, "R8 clear alias read");
    rd(8'h0C, 32'h0, "R8 toggle alias read");

    wr(8'h14, 32'h1234_5678);
    rd(8'h14, 32'h1234_5678, "R6 direction readback");
    chk("R6 pad_oe_o follows direction", pad_oe_o, 32'h1234_5678);

    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_FFFF, "R11 misaligned/unmapped write ignored");
    rd(8'h14, 32'h1234_5678, "R11 direction untouched");
    rd(8'h15, 32'h0, "R11 misaligned read zero");
    rd(8'h1C, 32'h0, "R11 unmapped read zero");

    // R7: pad change before edge a is visible to a read taken at edge a+2
    @(negedge clk_i);
    pad_in_i = 32'hCAFE_BABE;
    req_i = 1'b1; we_i = 1'b0; addr_i = 8'h10;
    @(negedge clk_i);
    chk("R7 pin one edge later", rdata_o, 32'h0);
    @(negedge clk_i);
    chk("R7 pin two edges later", rdata_o, 32'h0);
    @(negedge clk_i);
    chk("R7 pin after sync", rdata_o, 32'hCAFE_BABE);
    req_i = 1'b0;

    wr(8'h10, 32'h0000_0000);
    rd(8'h10, 32'hCAFE_BABE, "R7 pin write ignored");
    rd(8'h00, 32'h0000_FFFF, "R7 latch untouched by pin write");

    rd(8'h14, 32'h1234_5678, "R9 load");
    repeat (3) @(negedge clk_i);
    chk("R9 hold idle", rdata_o, 32'h1234_5678);
    wr(8'h00, 32'h5555_AAAA);
    chk("R9 hold over write", rdata_o, 32'h1234_5678);

    wr(8'h14, 32'h0);
    chk("R10 outputs with inputs dir", pad_out_o, 32'h5555_AAAA);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      req_i = $urandom_range(0, 3) != 0;
      we_i = $urandom_range(0, 1) == 1;
      addr_i = 8'($urandom_range(0, 31));
      wdata_i = $urandom;
      if ($urandom_range(0, 3) == 0) pad_in_i = $urandom;
    end
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule